// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-channel SPI master that software runs through a small bank of 16-bit registers. Software loads a transmit word of up to 32 bits as two halves, picks the serial clock rate, the clock idle level and the sampling edge, and then writes a command register. That command carries the word length and one or both operation bits: "send" and "receive". The controller runs one frame of that many bits on `sclk`/`mosi`/`miso`. When the frame ends it sets a sticky done flag for each operation requested. Software polls these flags or waits for the interrupt.

A receive operation latches the word captured from `miso` into a 32-bit receive register, which is read back as a low half and a high half. Every frame drives the transmit register onto `mosi`. A receive-only transfer therefore sends whatever the transmit register holds, and software loads zero there first. The serial clock runs only while the clock-enable bit is set. Slave-select lines come from a field of the command register. The register bus is a plain single-cycle write port with a combinational read mux. There is no streaming data path, so nothing at the edge of the block uses valid/ready.

Top module: `spim_ctrl`

## Requirements
- R1: After reset `sclk` and `mosi` are 0, all `cs_n` lines are 1, `irq` is 0, and the status and receive registers read 0.
- R2: Register words are selected by `reg_addr` as follows: 0 config-A, 1 config-B, 2 command, 3 status, 4 TX low, 5 TX high, 6 RX low, 7 RX high. Config-A holds the clock enable in bit 0, the divisor in bits 3:1, the send-done interrupt enable in bit 4 and the receive-done interrupt enable in bit 5. Config-B holds the sampling edge in bit 0 (1 = rising, 0 = falling), the `sclk` idle level in bit 5 and the interrupt pulse mode in bit 10. All other bits of these two registers read 0.
- R3: While clock enable is 0, a command write starts no frame: `sclk` does not toggle and no status flag sets.
- R4: A frame shifts the low N bits of the transmit word out on `mosi`, most significant bit first. Each bit is valid at its sampling edge.
- R5: When the command had the receive bit (bit 0) set, the end of the frame stores the N bits sampled from `miso` at the sampling edges, first bit as the most significant, zero-extended, into RX low/high. Status bit 0 then sets.
- R6: When the command had the send bit (bit 1) set, the end of the frame sets status bit 1. A frame without the receive bit leaves RX unchanged and does not set status bit 0.
- R7: The command size field in bits 6:2 holds N−1, so N runs from 4 to 32. Codes 0 to 2 are treated as N = 4. A frame has exactly 2N `sclk` transitions and N sampling edges.
- R8: Between frames `sclk` rests at the idle level from config-B. During a frame, each bit's sampling edge is the edge that config-B selects.
- R9: Any write to the status register clears both flags. A command that starts a frame clears only the flags of the operations it requests.
- R10: In level mode `irq` is high exactly while (status bit 0 AND receive-done enable) OR (status bit 1 AND send-done enable) holds.
- R11: In pulse mode `irq` is high for one cycle when that OR term rises.
- R12: Every `sclk` half period lasts 2^D clock cycles, where D is the divisor field.
- R13: A command write that arrives during a frame is ignored entirely. The stored command, the slave-select outputs and the running frame are unchanged.
- R14: Command bits 8:7 are a slave-select field. On every accepted command write `cs_n[i]` becomes the inverse of field bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low slave selects |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a frame that is already running when software acts again. Two effects must be seen while the shifter is busy: a fresh start clears only its matching flag, and a second command write has no effect. The bench gets there with a 32-bit frame at divisor 2, which keeps the shifter busy for well over a hundred cycles. Inside that window it reads the status register and writes a conflicting command with a different size and slave select. After the frame it checks the edge count, the stored command and `cs_n`. All four combinations of idle level and sampling edge are swept over word lengths from 4 to 32. A bench-side slave model drives `miso` on the opposite edge, so a wrong edge choice corrupts the data.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int IW       = $clog2(WORD_W);
  localparam int CNT_W    = IW + 1;
  localparam int DIV_W    = 3;
  localparam int SIZE_W   = 5;
  localparam int MIN_BITS = 4;

  localparam int A_EN_B   = 0;
  localparam int A_DIV_B  = 1;
  localparam int A_WIE_B  = 4;
  localparam int A_RIE_B  = 5;
  localparam int B_EDGE_B = 0;
  localparam int B_IDLE_B = 5;
  localparam int B_PULS_B = 10;
  localparam int C_RD_B   = 0;
  localparam int C_WR_B   = 1;
  localparam int C_SIZE_B = 2;
  localparam int C_SEL_B  = 7;
  localparam int F_RD_B   = 0;
  localparam int F_WR_B   = 1;

  typedef enum logic [2:0] {
    RS_CFGA = 3'd0, RS_CFGB = 3'd1, RS_CMD = 3'd2, RS_FLAG = 3'd3,
    RS_TXL  = 3'd4, RS_TXH  = 3'd5, RS_RXL = 3'd6, RS_RXH  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic             wr_ie;
    logic             rd_ie;
    logic             edge_rise;
    logic             idle_hi;
    logic             pulse;
  } cfg_t;
endpackage

// File: rtl/spim_clkgen.sv
`timescale 1ns/1ps
module spim_clkgen
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = (2 ** DIV_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = CW'((32'd1 << div_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R12: with a divisor above zero, ticks are never back to back
  assert_tick_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  bits_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              edge_rise_i,
  input  logic              idle_hi_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic              busy_q, done_q, sclk_q, mosi_q, edge_q;
  logic [CNT_W-1:0]  nbits_q, scnt_q;
  logic [CNT_W:0]    hc_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [IW-1:0]     idx;
  logic              nsclk, sampling, last_half;

  assign idx       = IW'(nbits_q - scnt_q - 1'b1);
  assign nsclk     = ~sclk_q;
  assign sampling  = (nsclk == edge_q);
  assign last_half = (hc_q == ({nbits_q, 1'b0} - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      edge_q  <= 1'b0;
      nbits_q <= '0;
      scnt_q  <= '0;
      hc_q    <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= idle_hi_i;
        if (start_i) begin
          busy_q  <= 1'b1;
          edge_q  <= edge_rise_i;
          nbits_q <= bits_i;
          scnt_q  <= '0;
          hc_q    <= '0;
          tx_q    <= tx_word_i;
          rx_q    <= '0;
          mosi_q  <= tx_word_i[IW'(bits_i - 1'b1)];
        end
      end else if (tick_i) begin
        sclk_q <= nsclk;
        hc_q   <= hc_q + 1'b1;
        if (sampling) begin
          rx_q   <= {rx_q[WORD_W-2:0], miso_i};
          scnt_q <= scnt_q + 1'b1;
        end else if (scnt_q < nbits_q) begin
          mosi_q <= tx_q[idx];
        end
        if (last_half) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign rx_word_o = rx_q;

  // R13: the register block never issues a start into a running frame
  assert_no_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i);
  // R7: a finished frame has taken exactly N samples
  assert_sample_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (scnt_q == nbits_q));
  // R8: the serial clock does not move while idle with a steady idle level
  assert_sclk_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i && sclk_q == idle_hi_i) |=> $stable(sclk_q));
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
  import spim_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output cfg_t              cfg_o,
  output logic              start_o,
  output logic [CNT_W-1:0]  start_bits_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic [NUM_CS-1:0] sel_o,
  output logic              irq_o
);
  reg_sel_e          rsel;
  cfg_t              cfg_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic [SIZE_W-1:0] size_q, size_w;
  logic              op_rd_q, op_wr_q;
  logic [NUM_CS-1:0] sel_q;
  logic [1:0]        flags_q, flags_n;
  logic              hit_cmd, hit_flag, lvl, lvl_q;

  assign rsel     = reg_sel_e'(bus_addr);
  assign hit_cmd  = bus_wr && (rsel == RS_CMD) && !busy_i;
  assign hit_flag = bus_wr && (rsel == RS_FLAG);
  assign size_w   = bus_wdata[C_SIZE_B +: SIZE_W];
  assign start_o  = hit_cmd && cfg_q.clk_en &&
                    (bus_wdata[C_RD_B] || bus_wdata[C_WR_B]);
  assign start_bits_o = (size_w < SIZE_W'(MIN_BITS - 1)) ? CNT_W'(MIN_BITS)
                                                         : CNT_W'(size_w) + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      tx_q    <= '0;
      size_q  <= '0;
      op_rd_q <= 1'b0;
      op_wr_q <= 1'b0;
      sel_q   <= '0;
    end else if (bus_wr) begin
      case (rsel)
        RS_CFGA: begin
          cfg_q.clk_en <= bus_wdata[A_EN_B];
          cfg_q.div    <= bus_wdata[A_DIV_B +: DIV_W];
          cfg_q.wr_ie  <= bus_wdata[A_WIE_B];
          cfg_q.rd_ie  <= bus_wdata[A_RIE_B];
        end
        RS_CFGB: begin
          cfg_q.edge_rise <= bus_wdata[B_EDGE_B];
          cfg_q.idle_hi   <= bus_wdata[B_IDLE_B];
          cfg_q.pulse     <= bus_wdata[B_PULS_B];
        end
        RS_TXL: tx_q[HALF_W-1:0]      <= bus_wdata;
        RS_TXH: tx_q[WORD_W-1:HALF_W] <= bus_wdata;
        RS_CMD: if (hit_cmd) begin
          op_rd_q <= bus_wdata[C_RD_B];
          op_wr_q <= bus_wdata[C_WR_B];
          size_q  <= size_w;
          sel_q   <= bus_wdata[C_SEL_B +: NUM_CS];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    flags_n = flags_q;
    if (hit_flag) flags_n = '0;
    if (start_o) begin
      if (bus_wdata[C_RD_B]) flags_n[F_RD_B] = 1'b0;
      if (bus_wdata[C_WR_B]) flags_n[F_WR_B] = 1'b0;
    end
    if (done_i) begin
      if (op_rd_q) flags_n[F_RD_B] = 1'b1;
      if (op_wr_q) flags_n[F_WR_B] = 1'b1;
    end
  end

  assign lvl = (flags_q[F_RD_B] && cfg_q.rd_ie) || (flags_q[F_WR_B] && cfg_q.wr_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rx_q    <= '0;
      lvl_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      lvl_q   <= lvl;
      if (done_i && op_rd_q) rx_q <= rx_word_i;
    end
  end

  assign irq_o = cfg_q.pulse ? (lvl && !lvl_q) : lvl;

  always_comb begin
    bus_rdata = '0;
    case (rsel)
      RS_CFGA: begin
        bus_rdata[A_EN_B]           = cfg_q.clk_en;
        bus_rdata[A_DIV_B +: DIV_W] = cfg_q.div;
        bus_rdata[A_WIE_B]          = cfg_q.wr_ie;
        bus_rdata[A_RIE_B]          = cfg_q.rd_ie;
      end
      RS_CFGB: begin
        bus_rdata[B_EDGE_B] = cfg_q.edge_rise;
        bus_rdata[B_IDLE_B] = cfg_q.idle_hi;
        bus_rdata[B_PULS_B] = cfg_q.pulse;
      end
      RS_CMD: begin
        bus_rdata[C_RD_B]             = op_rd_q;
        bus_rdata[C_WR_B]             = op_wr_q;
        bus_rdata[C_SIZE_B +: SIZE_W] = size_q;
        bus_rdata[C_SEL_B +: NUM_CS]  = sel_q;
      end
      RS_FLAG: bus_rdata[1:0] = flags_q;
      RS_TXL:  bus_rdata = tx_q[HALF_W-1:0];
      RS_TXH:  bus_rdata = tx_q[WORD_W-1:HALF_W];
      RS_RXL:  bus_rdata = rx_q[HALF_W-1:0];
      RS_RXH:  bus_rdata = rx_q[WORD_W-1:HALF_W];
      default: bus_rdata = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign tx_word_o = tx_q;
  assign sel_o     = sel_q;

  // R9: a status write with no completing frame leaves both flags clear
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !done_i) |=> (flags_q == 2'b00));
  // R5: a finishing receive frame raises the receive flag
  assert_rd_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && op_rd_q) |=> flags_q[F_RD_B]);
  // R6: a finishing send frame raises the send flag
  assert_wr_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && op_wr_q) |=> flags_q[F_WR_B]);
  // R11: a pulse-mode interrupt lasts a single cycle
  assert_pulse_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.pulse && irq_o) |=> !irq_o);
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  cfg_t              cfg;
  logic              start, busy, done, tick;
  logic [CNT_W-1:0]  start_bits;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [NUM_CS-1:0] sel;

  spim_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (reg_wr),
    .bus_addr     (reg_addr),
    .bus_wdata    (reg_wdata),
    .bus_rdata    (reg_rdata),
    .busy_i       (busy),
    .done_i       (done),
    .rx_word_i    (rx_word),
    .cfg_o        (cfg),
    .start_o      (start),
    .start_bits_o (start_bits),
    .tx_word_o    (tx_word),
    .sel_o        (sel),
    .irq_o        (irq)
  );

  spim_clkgen u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  spim_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .bits_i      (start_bits),
    .tx_word_i   (tx_word),
    .edge_rise_i (cfg.edge_rise),
    .idle_hi_i   (cfg.idle_hi),
    .tick_i      (tick),
    .miso_i      (miso),
    .busy_o      (busy),
    .done_o      (done),
    .sclk_o      (sclk),
    .mosi_o      (mosi),
    .rx_word_o   (rx_word)
  );

  assign cs_n = ~sel;
endmodule

// File: tb/tb_spim_ctrl.sv
`timescale 1ns/1ps
module tb_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;
  logic [1:0]  cs_n;

  spim_ctrl #(.NUM_CS(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench slave model and monitor
  int cyc = 0, last_t = 0, toggles = 0, nsamp = 0, half_err = 0, exp_half = 1, irq_hi = 0;
  bit have_t = 0;
  logic prev_sclk = 1'b0, m_edge = 1'b0;
  logic [31:0] got = '0, pat = '0;
  int m_size = 4;

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_hi++;
    if (sclk !== prev_sclk) begin
      if (have_t && (cyc - last_t) != exp_half) half_err++;
      have_t = 1; last_t = cyc; toggles++;
      if (sclk == m_edge) begin got = {got[30:0], mosi}; nsamp++; end
      else if (nsamp < m_size) miso = pat[m_size-1-nsamp];
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_wr = 1'b0; reg_addr = a; #1 d = reg_rdata;
  endtask

  // frame settings
  logic pulse_mode = 1'b0;
  logic [1:0] ie = 2'b00;        // {receive-done enable, send-done enable}
  int f_bits, f_d; logic f_rd, f_wr, f_idl;
  logic [31:0] f_mask, f_tx, f_p;
  logic [15:0] f_cmd;

  task automatic frame_start(input int code, input int d, input logic e, input logic idl,
                             input logic rd, input logic wr, input logic [31:0] tx,
                             input logic [31:0] p, input logic [1:0] sel);
    f_bits = (code < 3) ? 4 : code + 1;
    f_mask = (f_bits == 32) ? 32'hFFFF_FFFF : ((32'h1 << f_bits) - 1);
    f_d = d; f_rd = rd; f_wr = wr; f_idl = idl; f_tx = tx; f_p = p;
    wreg(3'd1, {5'b0, pulse_mode, 4'b0, idl, 4'b0, e});
    wreg(3'd0, {10'b0, ie[1], ie[0], 3'(d), 1'b1});
    wreg(3'd4, tx[15:0]);
    wreg(3'd5, tx[31:16]);
    @(negedge clk); #1;
    m_size = f_bits; m_edge = e; pat = p; got = '0; nsamp = 0; toggles = 0;
    half_err = 0; have_t = 0; exp_half = 1 << d; irq_hi = 0; prev_sclk = sclk;
    miso = p[f_bits-1];
    f_cmd = {7'b0, sel, 5'(code), wr, rd};
    wreg(3'd2, f_cmd);
  endtask

  task automatic frame_finish();
    logic [15:0] v, lo, hi;
    logic [1:0] want;
    want = {f_wr, f_rd};
    for (int i = 0; i < 6000; i++) begin
      rreg(3'd3, v);
      if ((v[1:0] & want) == want) break;
    end
    repeat (2) @(negedge clk);
    chk(toggles == 2 * f_bits, "R7 sclk transitions", 32'(toggles), 32'(2 * f_bits));
    chk(nsamp == f_bits, "R7 sampling edges", 32'(nsamp), 32'(f_bits));
    chk(half_err == 0, "R12 half period", 32'(half_err), 0);
    chk(sclk == f_idl, "R8 idle level", 32'(sclk), 32'(f_idl));
    if (f_wr) chk((got & f_mask) == (f_tx & f_mask), "R4 mosi word", got & f_mask, f_tx & f_mask);
    if (f_rd) begin
      rreg(3'd6, lo); rreg(3'd7, hi);
      chk({hi, lo} == (f_p & f_mask), "R5 rx word", {hi, lo}, f_p & f_mask);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, lo, hi;
    logic [31:0] keep;
    int sizes[8] = '{4, 7, 8, 13, 16, 17, 31, 32};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 0, "R1 sclk", 32'(sclk), 0);
    chk(mosi == 0, "R1 mosi", 32'(mosi), 0);
    chk(cs_n == 2'b11, "R1 cs_n", 32'(cs_n), 3);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    rreg(3'd3, v); chk(v == 0, "R1 status", 32'(v), 0);
    rreg(3'd6, v); chk(v == 0, "R1 rx low", 32'(v), 0);

    // R2 register layout readback
    wreg(3'd0, 16'hFFFF); rreg(3'd0, v); chk(v == 16'h003F, "R2 config-A", 32'(v), 32'h3F);
    wreg(3'd1, 16'hFFFF); rreg(3'd1, v); chk(v == 16'h0421, "R2 config-B", 32'(v), 32'h421);
    wreg(3'd5, 16'hBEEF); rreg(3'd5, v); chk(v == 16'hBEEF, "R2 tx high", 32'(v), 32'hBEEF);
    wreg(3'd0, 16'h0000); wreg(3'd1, 16'h0000);

    // R3 clock disabled: no frame; R14 select still latched
    @(negedge clk); #1; toggles = 0; prev_sclk = sclk;
    wreg(3'd2, {7'b0, 2'b01, 5'd7, 1'b1, 1'b1});
    repeat (40) @(negedge clk);
    chk(toggles == 0, "R3 no sclk activity", 32'(toggles), 0);
    rreg(3'd3, v); chk(v == 0, "R3 no flags", 32'(v), 0);
    chk(cs_n == 2'b10, "R14 cs_n from select field", 32'(cs_n), 2);

    // sweep modes and sizes, full duplex, divisor 0
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        frame_start(sizes[s] - 1, 0, m[0], m[1], 1'b1, 1'b1,
                    32'hA5C3_9E17 ^ (32'(sizes[s]) * 32'h0101_0101) ^ (32'(m) << 9),
                    32'h6B1D_F04C + 32'(sizes[s] * 977) + 32'(m * 31), 2'b00);
        frame_finish();
        rreg(3'd3, v); chk(v == 16'h0003, "R6 both flags", 32'(v), 3);
      end
    end

    // R12 divisor sweep
    for (int d = 1; d < 4; d++) begin
      frame_start(7, d, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_00C6 + 32'(d), 32'h0000_0039 + 32'(d), 2'b00);
      frame_finish();
    end

    // R7 size codes below 3 run 4-bit frames
    for (int c = 0; c < 3; c++) begin
      frame_start(c, 0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_000A + 32'(c), 32'h0000_0005 + 32'(c), 2'b00);
      frame_finish();
    end

    // R6 send-only keeps RX and receive flag untouched
    rreg(3'd6, lo); rreg(3'd7, hi); keep = {hi, lo};
    wreg(3'd3, 16'h0000);
    frame_start(15, 0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_F00D, 32'h0000_1234, 2'b00);
    frame_finish();
    rreg(3'd6, lo); rreg(3'd7, hi);
    chk({hi, lo} == keep, "R6 rx unchanged", {hi, lo}, keep);
    rreg(3'd3, v); chk(v == 16'h0002, "R6 only send flag", 32'(v), 2);

    // R5 receive-only with zero dummy word
    frame_start(11, 0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0000_0ABC, 2'b00);
    frame_finish();
    chk(got == 0, "R5 dummy word on mosi", got, 0);

    // R9 clear-all by status write
    frame_start(7, 0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h55, 32'hAA, 2'b00);
    frame_finish();
    wreg(3'd3, 16'h0000); rreg(3'd3, v); chk(v == 0, "R9 status write clears", 32'(v), 0);

    // R9 start clears only matching flag; R13 command ignored mid-frame
    frame_start(7, 0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h55, 32'hAA, 2'b00);
    frame_finish();
    frame_start(31, 2, 1'b1, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, 2'b01);
    rreg(3'd3, v); chk(v == 16'h0001, "R9 start clears matching flag", 32'(v), 1);
    wreg(3'd2, {7'b0, 2'b10, 5'd3, 1'b1, 1'b1});
    chk(cs_n == 2'b10, "R13 cs_n unchanged mid-frame", 32'(cs_n), 2);
    frame_finish();
    rreg(3'd2, v); chk(v == f_cmd, "R13 command unchanged", 32'(v), 32'(f_cmd));
    rreg(3'd3, v); chk(v == 16'h0003, "R13 flags after frame", 32'(v), 3);

    // R10 level interrupt
    wreg(3'd3, 16'h0000);
    ie = 2'b11;
    frame_start(7, 0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h12, 32'h34, 2'b00);
    frame_finish();
    chk(irq == 1, "R10 irq level high", 32'(irq), 1);
    wreg(3'd3, 16'h0000); @(negedge clk);
    chk(irq == 0, "R10 irq cleared", 32'(irq), 0);
    ie = 2'b10;   // receive-done only, send-only frame
    frame_start(7, 0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h12, 32'h34, 2'b00);
    frame_finish();
    chk(irq == 0, "R10 disabled flag no irq", 32'(irq), 0);

    // R11 pulse mode
    wreg(3'd3, 16'h0000);
    ie = 2'b11; pulse_mode = 1'b1;
    frame_start(9, 0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h3A5, 32'h15A, 2'b00);
    frame_finish();
    repeat (3) @(negedge clk);
    chk(irq_hi == 1, "R11 single pulse", 32'(irq_hi), 1);
    chk(irq == 0, "R11 irq low after pulse", 32'(irq), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule